// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small memory-mapped bank of board-level control and status registers on a single-beat 32-bit read/write bus. Software reads a fixed board identification word and drives eight user LEDs. It keeps two flag words and controls the active-low write-protect pin of a flash device. It can also observe two memory-card status pins and a strap that tells which of two daughterboard sites is the master.

Each flag word has two addresses. A write to the set address turns on the bits written as one, and a write to the clear address turns them off. Reading the set address returns the current value. Because of this, a single bit can be changed without a read-modify-write. One flag word is volatile. The other survives an ordinary reset and is cleared only by a separate power-on reset.

Asynchronous status pins pass through multi-flop synchronizers before software can see them. Read data is registered: it appears one cycle after the read is accepted.

Top module: `brd_ctl_bank`

## Requirements
- R1: A read of offset 0x000 returns {ID_REV[3:0], board_num[11:0], ID_BUILD[15:0]}, with the board number in bits 27:16. Writes to 0x000 change nothing.
- R2: Offset 0x008 is a read/write LED register whose bit i drives led_o[i]. It is zero after rst_n, and bits above the LED width read as zero.
- R3: A read of offset 0x030 returns the volatile flag word. A write there sets every bit written as 1 and leaves the other bits unchanged.
- R4: A write to offset 0x034 clears every volatile flag bit written as 1 and leaves the other bits unchanged. A read of 0x034 returns zero.
- R5: Offset 0x038 (read value and set-on-write) and offset 0x03C (clear-on-write, reads zero) do the same for the non-volatile flag word.
- R6: rst_n clears the volatile flags. The non-volatile flags keep their value through rst_n and are cleared only by por_n.
- R7: At offset 0x048, bit 0 reads the synchronized card-inserted pin and bit 1 reads the synchronized card write-protect pin, with all other bits zero. A pin level held for 3 clock edges before a read is the level that read returns. Writes to 0x048 change nothing.
- R8: Bit 0 of offset 0x04C is a read/write register that drives flash_wp_n_o (0 = flash protected). It is reset to 0 by rst_n, and the other bits read zero.
- R9: A read of offset 0x060 returns the synchronized master-site pin in bit 14 and zero in every other bit.
- R10: Offsets not listed above read as zero, and writes to them change no register. Address bits 1:0 are ignored.
- R11: bus_rdata carries the read value in the cycle after a read is accepted (bus_sel=1, bus_wr=0), and is zero in the cycle after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for all state except the non-volatile flags |
| por_n | input | 1 | Active-low synchronous power-on reset for the non-volatile flags |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| board_num | input | 12 | Board number strap |
| card_in_pin | input | 1 | Card-inserted pin, asynchronous |
| card_wp_pin | input | 1 | Card write-protect pin, asynchronous |
| master_site_pin | input | 1 | Master-site strap, asynchronous |
| led_o | output | 8 | User LED drives |
| flash_wp_n_o | output | 1 | Flash write-protect, active low |

## Verification
The hardest state to reach from the ports is a non-volatile flag word that still holds bits after rst_n has cleared the rest of the bank. Reaching it needs a reset pulse applied in the middle of a sequence of accesses, followed by a separate power-on pulse. The stimulus first fills both flag words through random set and clear writes. It then pulses rst_n alone, reads back every register, and only after that pulses por_n. Random accesses, mixed with stray writes to unmapped and read-only offsets, check that the set and clear aliases never disturb neighbouring bits or registers.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] OFS_ID     = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_LED    = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_VSET   = 12'h030;
   localparam logic [ADDR_W-1:0] OFS_VCLR   = 12'h034;
   localparam logic [ADDR_W-1:0] OFS_NVSET  = 12'h038;
   localparam logic [ADDR_W-1:0] OFS_NVCLR  = 12'h03C;
   localparam logic [ADDR_W-1:0] OFS_CARD   = 12'h048;
   localparam logic [ADDR_W-1:0] OFS_FLASH  = 12'h04C;
   localparam logic [ADDR_W-1:0] OFS_MISC   = 12'h060;
   localparam int MASTER_BIT = 14;

   typedef struct packed {
      logic id;
      logic led;
      logic vset;
      logic vclr;
      logic nvset;
      logic nvclr;
      logic card;
      logic flash;
      logic misc;
   } reg_sel_t;
endpackage

// File: rtl/brd_ctl_decode.sv
module brd_ctl_decode
   import brd_ctl_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel,
   output logic              hit
);
   logic [ADDR_W-1:0] word_ofs;

   always_comb begin
      word_ofs = {addr[ADDR_W-1:2], 2'b00};
      sel = '0;
      case (word_ofs)
         OFS_ID:    sel.id    = 1'b1;
         OFS_LED:   sel.led   = 1'b1;
         OFS_VSET:  sel.vset  = 1'b1;
         OFS_VCLR:  sel.vclr  = 1'b1;
         OFS_NVSET: sel.nvset = 1'b1;
         OFS_NVCLR: sel.nvclr = 1'b1;
         OFS_CARD:  sel.card  = 1'b1;
         OFS_FLASH: sel.flash = 1'b1;
         OFS_MISC:  sel.misc  = 1'b1;
         default:   sel = '0;
      endcase
      hit = |sel;
   end
endmodule

// File: rtl/brd_ctl_sync.sv
module brd_ctl_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("brd_ctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage[s] <= '0;
         else if (s == 0) stage[s] <= d;
         else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/brd_ctl_flagreg.sv
module brd_ctl_flagreg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("brd_ctl_flagreg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!clr_n)      q <= '0;
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end

   // R3 / R5: set alias turns on every written one
   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!clr_n)
      set_we |=> ((q & $past(wdata)) == $past(wdata)));
   // R4 / R5: clear alias turns off every written one
   assert_flag_clr_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));
   // R3 / R4: untouched bits keep their value
   assert_flag_keep_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (set_we || clr_we) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
   // R10: no alias strobe, no change
   assert_flag_idle_R10: assert property (@(posedge clk) disable iff (!clr_n)
      (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/brd_ctl_bank.sv
module brd_ctl_bank
   import brd_ctl_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          LED_W       = 8,
   parameter int          BOARD_W     = 12,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  ID_REV      = 4'h1,
   parameter logic [15:0] ID_BUILD    = 16'h0C0D,
   parameter logic        WPN_RST     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [BOARD_W-1:0] board_num,
   input  logic              card_in_pin,
   input  logic              card_wp_pin,
   input  logic              master_site_pin,
   output logic [LED_W-1:0]  led_o,
   output logic              flash_wp_n_o
);
   localparam int ID_LO    = 16;
   localparam int ID_HI    = ID_LO + BOARD_W - 1;
   localparam int N_SYNC   = 3;

   if (DATA_W != 32) begin : g_bad_data
      $error("brd_ctl_bank: DATA_W must be 32");
   end
   if (LED_W < 1 || LED_W > DATA_W) begin : g_bad_led
      $error("brd_ctl_bank: LED_W out of range");
   end
   if (BOARD_W != 12) begin : g_bad_board
      $error("brd_ctl_bank: BOARD_W must be 12 to fit bits 27:16");
   end

   reg_sel_t sel;
   logic     hit;
   logic     wr_acc, rd_acc;

   brd_ctl_decode u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   assign wr_acc = bus_sel &  bus_wr;
   assign rd_acc = bus_sel & ~bus_wr;

   // flag words
   logic [DATA_W-1:0] vflags, nvflags;

   brd_ctl_flagreg #(.W(DATA_W)) u_vflags (
      .clk    (clk),
      .clr_n  (rst_n),
      .set_we (wr_acc & sel.vset),
      .clr_we (wr_acc & sel.vclr),
      .wdata  (bus_wdata),
      .q      (vflags)
   );

   brd_ctl_flagreg #(.W(DATA_W)) u_nvflags (
      .clk    (clk),
      .clr_n  (por_n),
      .set_we (wr_acc & sel.nvset),
      .clr_we (wr_acc & sel.nvclr),
      .wdata  (bus_wdata),
      .q      (nvflags)
   );

   // synchronized pins: {master, card_wp, card_in}
   logic [N_SYNC-1:0] pin_sync;

   brd_ctl_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({master_site_pin, card_wp_pin, card_in_pin}),
      .q     (pin_sync)
   );

   // LED and flash write-protect registers
   logic [LED_W-1:0] led_q;
   logic             wpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led_q <= '0;
         wpn_q <= WPN_RST;
      end else if (wr_acc) begin
         if (sel.led)   led_q <= bus_wdata[LED_W-1:0];
         if (sel.flash) wpn_q <= bus_wdata[0];
      end
   end

   assign led_o        = led_q;
   assign flash_wp_n_o = wpn_q;

   // read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         sel.id: begin
            rd_mux[DATA_W-1 -: 4]   = ID_REV;
            rd_mux[ID_HI:ID_LO]     = board_num;
            rd_mux[ID_LO-1:0]       = ID_BUILD;
         end
         sel.led:   rd_mux[LED_W-1:0] = led_q;
         sel.vset:  rd_mux = vflags;
         sel.nvset: rd_mux = nvflags;
         sel.card:  rd_mux[1:0] = pin_sync[1:0];
         sel.flash: rd_mux[0] = wpn_q;
         sel.misc:  rd_mux[MASTER_BIT] = pin_sync[2];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   // R2: LED write reaches the pins on the next cycle
   assert_led_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && sel.led) |=> (led_o == $past(bus_wdata[LED_W-1:0])));
   // R8: flash write-protect follows bit 0 of a write
   assert_wpn_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && sel.flash) |=> (flash_wp_n_o == $past(bus_wdata[0])));
   // R2 / R8: outputs hold when their register is not written
   assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && (sel.led || sel.flash)) |=> ($stable(led_o) && $stable(flash_wp_n_o)));
   // R10: unmapped reads return zero
   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && !hit) |=> (bus_rdata == '0));
   // R1: identification word carries the board strap
   assert_id_board_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && sel.id) |=> (bus_rdata[ID_HI:ID_LO] == $past(board_num)));
   // R9: misc word has only the master bit
   assert_misc_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && sel.misc) |=> ($countones(bus_rdata) <= 1));
endmodule

// File: tb/brd_ctl_bank_tb_top.sv
module brd_ctl_bank_tb_top;
   localparam logic [3:0]  T_REV   = 4'h3;
   localparam logic [15:0] T_BUILD = 16'h7E21;
   localparam int          WD_MAX  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, por_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] board_num = 12'hA5C;
   logic        card_in_pin = 1'b0, card_wp_pin = 1'b0, master_site_pin = 1'b0;
   logic [7:0]  led_o;
   logic        flash_wp_n_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model state
   logic [7:0]  m_led;
   logic [31:0] m_vf, m_nv;
   logic        m_wp;

   always #10 clk = ~clk;

   brd_ctl_bank #(.ID_REV(T_REV), .ID_BUILD(T_BUILD)) dut_i (
      .clk, .rst_n, .por_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
      .bus_rdata, .board_num, .card_in_pin, .card_wp_pin, .master_site_pin,
      .led_o, .flash_wp_n_o
   );

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [11:0] w;
      w = {a[11:2], 2'b00};
      case (w)
         12'h000: return {T_REV, board_num, T_BUILD};
         12'h008: return {24'h0, m_led};
         12'h030: return m_vf;
         12'h038: return m_nv;
         12'h048: return {30'h0, card_wp_pin, card_in_pin};
         12'h04C: return {31'h0, m_wp};
         12'h060: return {17'h0, master_site_pin, 14'h0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      logic [11:0] w;
      w = {a[11:2], 2'b00};
      case (w)
         12'h000: return "R1";
         12'h008: return "R2";
         12'h030: return "R3";
         12'h034: return "R4";
         12'h038, 12'h03C: return "R5";
         12'h048: return "R7";
         12'h04C: return "R8";
         12'h060: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
      logic [11:0] w;
      w = {a[11:2], 2'b00};
      case (w)
         12'h008: m_led = d[7:0];
         12'h030: m_vf = m_vf | d;
         12'h034: m_vf = m_vf & ~d;
         12'h038: m_nv = m_nv | d;
         12'h03C: m_nv = m_nv & ~d;
         12'h04C: m_wp = d[0];
         default: ;
      endcase
   endfunction

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input logic [11:0] a);
      logic [31:0] d;
      bus_read(a, d);
      chk(req_of(a), d, exp_read(a));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (WD_MAX) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      logic [31:0] d;
      logic [11:0] a;
      void'($urandom(32'h5EED_0042));
      m_led = '0; m_vf = '0; m_nv = '0; m_wp = 1'b0;

      idle(3);
      rst_n = 1'b1; por_n = 1'b1;
      idle(4);

      // reset state
      chk("R2 reset led_o", {24'h0, led_o}, 32'h0);
      chk("R8 reset flash_wp_n_o", {31'h0, flash_wp_n_o}, 32'h0);
      chk("R11 idle rdata", bus_rdata, 32'h0);
      rd_chk(12'h000);
      rd_chk(12'h030);
      rd_chk(12'h038);
      rd_chk(12'h060);

      // R1: write to ID ignored
      bus_write(12'h000, 32'hFFFF_FFFF);
      rd_chk(12'h000);

      // R3 / R4: set then clear patterns
      bus_write(12'h030, 32'h8000_0011);
      bus_write(12'h030, 32'h0000_0100);
      bus_read(12'h030, d);
      chk("R3 set accumulates", d, 32'h8000_0111);
      bus_write(12'h034, 32'h0000_0010);
      bus_read(12'h030, d);
      chk("R4 clear one bit", d, 32'h8000_0101);
      bus_read(12'h034, d);
      chk("R4 clear alias reads zero", d, 32'h0);

      // R2 LED pins
      bus_write(12'h008, 32'hFFFF_FF5A);
      chk("R2 led_o after write", {24'h0, led_o}, 32'h5A);
      rd_chk(12'h008);

      // R8 flash write-protect
      bus_write(12'h04C, 32'hFFFF_FFFF);
      chk("R8 flash_wp_n_o set", {31'h0, flash_wp_n_o}, 32'h1);
      rd_chk(12'h04C);

      // R7 / R9 synchronized pins, byte offset low bits ignored (R10)
      card_in_pin = 1'b1; master_site_pin = 1'b1;
      idle(4);
      rd_chk(12'h048);
      rd_chk(12'h063);
      card_in_pin = 1'b0; card_wp_pin = 1'b1;
      idle(4);
      bus_write(12'h048, 32'h0000_0001);
      bus_read(12'h048, d);
      chk("R7 card bits, write ignored", d, 32'h2);

      // R11: read value lasts one cycle only
      bus_read(12'h000, d);
      @(negedge clk);
      chk("R11 rdata returns to zero", bus_rdata, 32'h0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int k;
         k = $urandom_range(0, 13);
         case (k)
            0: a = 12'h000;  1: a = 12'h008;  2: a = 12'h030;  3: a = 12'h034;
            4: a = 12'h038;  5: a = 12'h03C;  6: a = 12'h048;  7: a = 12'h04C;
            8: a = 12'h060;  9: a = 12'h030;  10: a = 12'h038;
            default: a = 12'($urandom_range(0, 4095));
         endcase
         if ($urandom_range(0, 1) == 1) bus_write(a, $urandom());
         else rd_chk(a);
      end

      // R6: rst_n keeps non-volatile flags
      bus_write(12'h038, 32'h00C0_FFEE);
      bus_write(12'h030, 32'h1234_5678);
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      m_led = '0; m_vf = '0; m_wp = 1'b0;
      idle(4);
      chk("R6 led_o after rst_n", {24'h0, led_o}, 32'h0);
      bus_read(12'h030, d);
      chk("R6 volatile flags cleared", d, 32'h0);
      bus_read(12'h038, d);
      chk("R6 non-volatile flags kept", d, m_nv);
      rd_chk(12'h04C);

      // R6: power-on reset clears non-volatile flags
      @(negedge clk); por_n = 1'b0;
      idle(2);
      por_n = 1'b1;
      m_nv = '0;
      bus_read(12'h038, d);
      chk("R6 non-volatile cleared by por_n", d, 32'h0);

      // R5 after por_n
      bus_write(12'h038, 32'h0000_00F0);
      bus_write(12'h03C, 32'h0000_0030);
      bus_read(12'h038, d);
      chk("R5 set/clear non-volatile", d, 32'h0000_00C0);

      idle(2);
      finish_run();
   end
endmodule